// File: doc/BRIEF.md
# Receive FIFO with Deferred Error Tagging

This block buffers characters coming out of a serial receiver core. Each character is written together with a three-bit error tag that records a frame error, a parity error or a break condition. The tag travels through the queue in lockstep with its character. An error interrupt is raised only when a tagged character becomes the oldest entry, which is the one the next data read returns. An error on a character that is still waiting behind others raises nothing.

Software reads characters through a data pop strobe and reads errors through a status strobe. A pending error is dismissed only after both the tagged character and the status have been read, in either order. A character that arrives while the queue is full is dropped, and a sticky overrun bit records the loss. That bit also drives the interrupt until the next status read. The fill level and a full flag are reported continuously.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters come out of `rd_data_o` in arrival order. `rd_data_o` always shows the oldest stored character, and a pulse on `rd_pop_i` removes it.
- R2: With the default depth of 16, `level_o` gives the number of stored entries modulo 16. `full_o` is 1 exactly when 16 entries are held. An accepted write without a pop raises the count by one at the next edge.
- R3: The status word `stat_o` uses these bit positions: bit0 frame, bit1 parity, bit2 break, bit3 overrun. Bits 2..0 show the tag of the oldest entry only, and only while an error is pending. `err_irq_o` is 1 exactly when `stat_o` is nonzero.
- R4: Once a tag is pending, it keeps showing in `stat_o` and keeps the interrupt raised. It clears only after both of these have happened: the tagged character has been popped, and `stat_rd_i` has been pulsed.
- R5: A write that arrives while the queue is full, with no pop in the same cycle, sets `stat_o` bit3 at the next edge.
- R6: Such an overrunning write is discarded. The stored entries, the oldest character and the full state stay unchanged.
- R7: While the queue is empty, `rd_data_o` reads 0. A pop strobe on an empty queue leaves the level and the pointers unchanged.
- R8: After reset the queue is empty, no error is pending, and every output is 0.
- R9: A pulse on `stat_rd_i` clears the overrun bit, unless a new overrun occurs in that same cycle.
- R10: An error on a character that is queued behind an error-free head raises no interrupt.
- R11: A write and a pop in the same cycle on a full queue are both accepted. The queue stays full and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Character strobe from the receiver core |
| wr_data_i | input | DATA_W | Received character |
| wr_frame_err_i | input | 1 | Frame error flag for this character |
| wr_parity_err_i | input | 1 | Parity error flag for this character |
| wr_break_i | input | 1 | Break detected with this character |
| rd_pop_i | input | 1 | Data read strobe, removes the oldest entry |
| rd_data_o | output | DATA_W | Oldest character, 0 when empty |
| stat_rd_i | input | 1 | Status read strobe |
| stat_o | output | 4 | {overrun, break, parity, frame} |
| err_irq_o | output | 1 | Error interrupt |
| level_o | output | $clog2(DEPTH) | Fill level |
| full_o | output | 1 | Queue holds DEPTH entries |

## Verification
The directed sequence queues five characters, with a frame error on the second and a parity error on the fourth. It is read back in two ways: once with the status read after the data pop, and once with the status read before it. This separates deferral at enqueue time from interrupts that are tied to the head entry, and it shows that the clear needs both reads. A fill-to-full pattern adds an extra write, a status read and a combined write-plus-pop. These tell a dropped overrun character apart from an accepted one. A separate break-tagged entry is read with the data pop and the status read in the same cycle. Finally, random traffic with simultaneous pushes, pops, status reads and random tags is compared every cycle against a queue-based model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int TAG_W  = 3;
   localparam int STAT_W = TAG_W + 1;
   localparam int FRM_BIT = 0;
   localparam int PAR_BIT = 1;
   localparam int BRK_BIT = 2;
   localparam int OVR_BIT = 3;

   typedef struct packed {
      logic brk;
      logic par;
      logic frm;
   } err_tag_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int ENTRY_W = 11,
   parameter int DEPTH   = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic               pop_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   output logic [ENTRY_W-1:0] head_o,
   output logic [CW-1:0]      count_o,
   output logic               full_o,
   output logic               empty_o,
   output logic               popped_o,
   output logic               overrun_o
);
   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
   logic [CW-1:0] count_q;
   logic pop_ok, push_ok;

   assign empty_o   = (count_q == '0);
   assign full_o    = (count_q == CW'(DEPTH));
   assign pop_ok    = pop_i & ~empty_o;
   assign push_ok   = push_i & (~full_o | pop_ok);
   assign overrun_o = push_i & full_o & ~pop_ok;
   assign popped_o  = pop_ok;
   assign count_o   = count_q;
   assign head_o    = slot_q[rd_ptr_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_ptr_inc = wr_ptr_q + AW'(1);
         assign rd_ptr_inc = rd_ptr_q + AW'(1);
      end else begin : g_cmp_wrap
         assign wr_ptr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
         assign rd_ptr_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      end
   endgenerate

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[i] <= '0;
            else if (push_ok && (wr_ptr_q == AW'(i)))
               slot_q[i] <= wdata_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_inc;
         if (pop_ok)  rd_ptr_q <= rd_ptr_inc;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end
endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track
   import rxq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              empty_i,
   input  logic [TAG_W-1:0]  head_tag_i,
   input  logic              popped_i,
   input  logic              stat_rd_i,
   input  logic              overrun_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   logic             held_q, data_done_q, stat_done_q, ovr_q;
   logic [TAG_W-1:0] tag_q;
   logic             capture, live;
   logic [TAG_W-1:0] live_tag;
   logic             data_done_n, stat_done_n;

   // A tagged head becomes pending in the same cycle it reaches the read side
   assign capture  = ~held_q & ~empty_i & (|head_tag_i);
   assign live     = held_q | capture;
   assign live_tag = held_q ? tag_q : (capture ? head_tag_i : '0);

   always_comb begin
      data_done_n = held_q ? (data_done_q | popped_i) : popped_i;
      stat_done_n = held_q ? (stat_done_q | stat_rd_i) : stat_rd_i;
   end

   assign stat_o = {ovr_q, live_tag};
   assign irq_o  = live | ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q      <= 1'b0;
         tag_q       <= '0;
         data_done_q <= 1'b0;
         stat_done_q <= 1'b0;
         ovr_q       <= 1'b0;
      end else begin
         ovr_q <= (ovr_q & ~stat_rd_i) | overrun_i;
         if (live && data_done_n && stat_done_n) begin
            held_q      <= 1'b0;
            tag_q       <= '0;
            data_done_q <= 1'b0;
            stat_done_q <= 1'b0;
         end else if (live) begin
            held_q      <= 1'b1;
            tag_q       <= live_tag;
            data_done_q <= data_done_n;
            stat_done_q <= stat_done_n;
         end
      end
   end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int ENTRY_W = DATA_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_frame_err_i,
   input  logic              wr_parity_err_i,
   input  logic              wr_break_i,
   input  logic              rd_pop_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              stat_rd_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              err_irq_o,
   output logic [AW-1:0]     level_o,
   output logic              full_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_err_fifo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_err_fifo: DEPTH must be at least 2");
      end
   endgenerate

   err_tag_t           in_tag;
   logic [ENTRY_W-1:0] wr_entry, head_entry;
   logic [CW-1:0]      count;
   logic               empty, popped, overrun;

   assign in_tag   = '{brk: wr_break_i, par: wr_parity_err_i, frm: wr_frame_err_i};
   assign wr_entry = {in_tag, wr_data_i};

   rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (wr_valid_i),
      .pop_i     (rd_pop_i),
      .wdata_i   (wr_entry),
      .head_o    (head_entry),
      .count_o   (count),
      .full_o    (full_o),
      .empty_o   (empty),
      .popped_o  (popped),
      .overrun_o (overrun)
   );

   rxq_err_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .empty_i    (empty),
      .head_tag_i (head_entry[ENTRY_W-1:DATA_W]),
      .popped_i   (popped),
      .stat_rd_i  (stat_rd_i),
      .overrun_i  (overrun),
      .stat_o     (stat_o),
      .irq_o      (err_irq_o)
   );

   assign rd_data_o = empty ? '0 : head_entry[DATA_W-1:0];
   assign level_o   = count[AW-1:0];
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid_i,
   input logic              rd_pop_i,
   input logic              stat_rd_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [3:0]        stat_o,
   input logic              err_irq_o,
   input logic [AW-1:0]     level_o,
   input logic              full_o
);
   logic [CW-1:0] cnt;
   logic          is_empty, ovr_evt;
   assign cnt      = full_o ? CW'(DEPTH) : CW'(level_o);
   assign is_empty = ~full_o & (level_o == '0);
   assign ovr_evt  = wr_valid_i & full_o & ~rd_pop_i;

   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !full_o && !(rd_pop_i && !is_empty)) |=> (cnt == $past(cnt) + CW'(1)));

   a_r3_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq_o == (stat_o != 4'd0));

   a_r4_tag_held_unread: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o[2:0] != 3'd0) && !rd_pop_i && !stat_rd_i) |=> ($stable(stat_o[2:0]) && err_irq_o));

   a_r5_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> stat_o[3]);

   a_r6_overrun_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> (full_o && $stable(rd_data_o)));

   a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty |-> (rd_data_o == '0));

   a_r9_status_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !ovr_evt) |=> !stat_o[3]);
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid_i (wr_valid_i),
   .rd_pop_i   (rd_pop_i),
   .stat_rd_i  (stat_rd_i),
   .rd_data_o  (rd_data_o),
   .stat_o     (stat_o),
   .err_irq_o  (err_irq_o),
   .level_o    (level_o),
   .full_o     (full_o)
);

// File: tb/tb_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_rx_err_fifo;
   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int MAX_CYC = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid_i = 0, wr_frame_err_i = 0, wr_parity_err_i = 0, wr_break_i = 0;
   logic [DW-1:0] wr_data_i = '0;
   logic          rd_pop_i = 0, stat_rd_i = 0;
   logic [DW-1:0] rd_data_o;
   logic [3:0]    stat_o;
   logic          err_irq_o;
   logic [3:0]    level_o;
   logic          full_o;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
      .wr_frame_err_i(wr_frame_err_i), .wr_parity_err_i(wr_parity_err_i),
      .wr_break_i(wr_break_i), .rd_pop_i(rd_pop_i), .rd_data_o(rd_data_o),
      .stat_rd_i(stat_rd_i), .stat_o(stat_o), .err_irq_o(err_irq_o),
      .level_o(level_o), .full_o(full_o));

   // reference model: queue of {tag, data} plus a pending-error record
   logic [10:0] q[$];
   bit       m_ovr = 0, m_held = 0, m_dd = 0, m_sd = 0;
   bit [2:0] m_tag = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input bit wr, input bit [7:0] d, input bit [2:0] t,
                       input bit rd, input bit st);
      bit empty, full, cap, live, pop, dd, sd;
      bit [2:0] htag, ltag;
      bit [3:0] e_stat;
      bit [7:0] e_data;
      @(negedge clk);
      wr_valid_i = wr; wr_data_i = d;
      wr_frame_err_i = t[0]; wr_parity_err_i = t[1]; wr_break_i = t[2];
      rd_pop_i = rd; stat_rd_i = st;
      #1;
      empty  = (q.size() == 0);
      full   = (q.size() == DEPTH);
      htag   = empty ? 3'd0 : q[0][10:8];
      e_data = empty ? 8'd0 : q[0][7:0];
      cap    = !m_held && !empty && (htag != 0);
      live   = m_held || cap;
      ltag   = m_held ? m_tag : (cap ? htag : 3'd0);
      e_stat = {m_ovr, ltag};
      chk(rd_data_o == e_data, "R1 head data", rd_data_o, e_data);
      chk(level_o == 4'(q.size()) && full_o == full, "R2 level/full",
          {full_o, level_o}, {full, 4'(q.size())});
      chk(stat_o == e_stat, "R4 status word", stat_o, e_stat);
      chk(err_irq_o == (live || m_ovr), "R3 irq", err_irq_o, live || m_ovr);
      pop = rd && !empty;
      dd  = m_held ? (m_dd || pop) : pop;
      sd  = m_held ? (m_sd || st) : st;
      m_ovr = (m_ovr && !st) || (wr && full && !pop);
      if (live && dd && sd) begin
         m_held = 0; m_tag = 0; m_dd = 0; m_sd = 0;
      end else if (live) begin
         m_held = 1; m_tag = ltag; m_dd = dd; m_sd = sd;
      end
      if (pop) void'(q.pop_front());
      if (wr && (!full || pop)) q.push_back({t, d});
   endtask

   task automatic idle();
      step(0, 8'h00, 3'd0, 0, 0);
   endtask

   initial begin
      #(MAX_CYC * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R8 reset state
      chk(level_o == 0 && !full_o, "R8 reset level", {full_o, level_o}, 0);
      chk(stat_o == 0 && !err_irq_o, "R8 reset status", {err_irq_o, stat_o}, 0);
      chk(rd_data_o == 0, "R8 reset data", rd_data_o, 0);
      @(negedge clk); rst_n = 1'b1;

      // five characters, frame error on the 2nd, parity error on the 4th
      step(1, 8'hA1, 3'b000, 0, 0);
      step(1, 8'hB2, 3'b001, 0, 0);
      step(1, 8'hC3, 3'b000, 0, 0);
      step(1, 8'hD4, 3'b010, 0, 0);
      step(1, 8'hE5, 3'b000, 0, 0);
      idle();
      chk(err_irq_o == 0, "R10 queued errors deferred", err_irq_o, 0);
      step(0, 0, 0, 1, 0); idle();
      chk(err_irq_o == 1 && stat_o == 4'b0001, "R3 frame tag at head", stat_o, 1);
      step(0, 0, 0, 1, 0); idle();
      chk(err_irq_o == 1 && stat_o == 4'b0001, "R4 held after data read", stat_o, 1);
      chk(rd_data_o == 8'hC3, "R1 order", rd_data_o, 8'hC3);
      step(0, 0, 0, 0, 1); idle();
      chk(err_irq_o == 0, "R4 cleared after both reads", err_irq_o, 0);
      step(0, 0, 0, 1, 0); idle();
      chk(stat_o == 4'b0010 && err_irq_o, "R3 parity tag at head", stat_o, 2);
      step(0, 0, 0, 0, 1); idle();
      chk(err_irq_o == 1, "R4 held after status read only", err_irq_o, 1);
      step(0, 0, 0, 1, 0); idle();
      chk(err_irq_o == 0 && rd_data_o == 8'hE5, "R4 cleared, head E", rd_data_o, 8'hE5);
      step(0, 0, 0, 1, 0); idle();
      step(0, 0, 0, 1, 0); idle();
      chk(level_o == 0 && rd_data_o == 0 && !full_o, "R7 empty read", {level_o, rd_data_o}, 0);

      // fill, overrun, clear, write+pop while full
      for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 3'd0, 0, 0);
      idle();
      chk(full_o && level_o == 0, "R2 full at depth", {full_o, level_o}, 5'h10);
      step(1, 8'hEE, 3'd0, 0, 0); idle();
      chk(stat_o[3] && err_irq_o, "R5 overrun flagged", stat_o, 8);
      chk(full_o && rd_data_o == 8'h10, "R6 overrun dropped", rd_data_o, 8'h10);
      step(0, 0, 0, 0, 1); idle();
      chk(stat_o == 0 && !err_irq_o, "R9 status read clears overrun", stat_o, 0);
      step(1, 8'h77, 3'd0, 1, 0); idle();
      chk(full_o && stat_o == 0 && rd_data_o == 8'h11, "R11 write+pop when full",
          {stat_o, rd_data_o}, 8'h11);
      for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0);
      idle();
      chk(level_o == 0 && !full_o, "R2 drained", level_o, 0);

      // break tag, both reads in the same cycle
      step(1, 8'h5A, 3'b100, 0, 0); idle();
      chk(stat_o == 4'b0100 && err_irq_o, "R1 break tag stored", stat_o, 4);
      step(0, 0, 0, 1, 1); idle();
      chk(!err_irq_o && level_o == 0, "R4 joint clear", err_irq_o, 0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         bit [2:0] t;
         t = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
         step($urandom_range(0, 99) < 55, 8'($urandom), t,
              $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 20);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule